// File: doc/BRIEF.md
# Fully Associative Tag Directory with Linked-List Recency

This block holds the tags and the replacement order of a fully associative cache whose lines are 64 bytes. A lookup drops the byte offset from a 32-bit address and compares the remaining tag against every line in the same cycle. It answers hit or miss, the index of the line it acted on, and the current least recently used line together with that line's write-back flag. Data storage, refill traffic and bus traffic belong to neighbouring blocks.

Recency is a doubly linked list of line indices held beside the tags, with head (most recent) and tail (least recent) registers. After a hit or a fill the touched line is taken out of its place in the list in one cycle and spliced in at the head in the next. Every neighbour update is decided per line by parallel index compares. While this update is running the block holds its ready output low, so a new lookup always sees a consistent list.

A caller presents an address with a read/write flag and a fill flag under a valid/ready handshake. On a miss, the caller reads the victim index and dirty flag from the response, writes back if needed, and then issues a fill with the same address so that the new tag lands in the victim line.

Top module: `fa_tag_dir`

## Requirements
- R1: After reset, req_ready is 1, rsp_valid is 0 and every line is invalid, so the first lookup misses and names line LINES-1 as a clean victim.
- R2: The tag is address bits [31:6]; two addresses that differ only in bits [5:0] select the same line.
- R3: One response is produced per accepted request, as a single-cycle rsp_valid pulse that is visible after the second rising edge following acceptance. On a hit, rsp_hit is 1 and rsp_idx is the line holding the tag.
- R4: Every response carries rsp_victim_idx, the least recently used line, and rsp_victim_dirty, that line's dirty flag, as they stood before the request. On a miss, rsp_hit is 0 and rsp_idx equals the victim.
- R5: A write (req_write=1, req_fill=0) that hits sets the dirty flag of the hit line. A write that misses changes no state.
- R6: A fill writes the tag into the hit line, or into the victim line on a miss. It sets that line valid, clears its dirty flag and ignores req_write. No two valid lines ever hold the same tag.
- R7: A hit or a fill makes the line most recently used. The relative order of all other lines is unchanged. A miss without fill changes nothing.
- R8: After accepting a hit or a fill, req_ready is low for exactly 3 cycles. After a miss without fill it is low for exactly 1 cycle.
- R9: A request presented while req_ready is low is not accepted and produces no response or state change.
- R10: At reset the lines are chained in index order with line 0 most recent, so consecutive fills after reset land in lines LINES-1, LINES-2, ..., 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | ADDR_W | Byte address of the access |
| req_write | input | 1 | Access is a write |
| req_fill | input | 1 | Install the tag and make the line most recent |
| rsp_valid | output | 1 | Single-cycle response strobe |
| rsp_hit | output | 1 | Tag matched a valid line |
| rsp_idx | output | IDX_W | Line hit, or line chosen on a miss |
| rsp_victim_idx | output | IDX_W | Least recently used line |
| rsp_victim_dirty | output | 1 | Dirty flag of that line |

## Verification
The parallel match and the victim report fall in the same cycle when a hit lands on the tail line. The response must then name that line both as the hit and as the victim. The following unlink must also pull the tail back to its predecessor. The bench provokes this repeatedly with a random stream over a small pool of tags on an 8-line configuration, so that hits on the tail are frequent. It judges every response against a move-to-front model of the recency order computed in the bench. Each later miss exposes whether the tail was moved correctly.

// File: rtl/fa_pkg.sv
// Shared types for the fully associative tag directory.
package fa_pkg;

    // Control sequence: accept, match, unlink, relink.
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_MATCH  = 2'd1,
        ST_UNLINK = 2'd2,
        ST_RELINK = 2'd3
    } fa_state_e;

endpackage

// File: rtl/fa_tag_match.sv
// Parallel tag comparator with lowest-index priority encoder.
// Assumes: line_vld qualifies each stored tag; purely combinational.
module fa_tag_match #(
    parameter int LINES = 1024,
    parameter int TAG_W = 26,
    parameter int IDX_W = 10
) (
    input  logic [LINES-1:0][TAG_W-1:0] line_tag,
    input  logic [LINES-1:0]            line_vld,
    input  logic [TAG_W-1:0]            probe,
    output logic [LINES-1:0]            match_vec,
    output logic                        any_hit,
    output logic [IDX_W-1:0]            hit_line
);

    // One equality comparator per line, all evaluated together.
    for (genvar g = 0; g < LINES; g++) begin : g_cmp
        assign match_vec[g] = line_vld[g] && (line_tag[g] == probe);
    end

    // Priority encode: the lowest matching index wins.
    always_comb begin
        hit_line = '0;
        for (int k = LINES - 1; k >= 0; k--) begin
            if (match_vec[k]) hit_line = IDX_W'(k);
        end
    end

    assign any_hit = |match_vec;

endmodule

// File: rtl/fa_lru_chain.sv
// Doubly linked recency list of line indices with head and tail registers.
// Assumes: the caller raises unlink_en then relink_en on consecutive cycles
// for the same tgt, and never for a tgt that is already the head.
module fa_lru_chain #(
    parameter int LINES = 1024,
    parameter int IDX_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             unlink_en,
    input  logic             relink_en,
    input  logic [IDX_W-1:0] tgt,
    output logic [IDX_W-1:0] head,
    output logic [IDX_W-1:0] tail
);

    logic [LINES-1:0][IDX_W-1:0] nxt_q;   // towards less recent
    logic [LINES-1:0][IDX_W-1:0] prv_q;   // towards more recent
    logic [IDX_W-1:0]            head_q;
    logic [IDX_W-1:0]            tail_q;
    logic [IDX_W-1:0]            tgt_nxt;
    logic [IDX_W-1:0]            tgt_prv;

    assign tgt_nxt = nxt_q[tgt];
    assign tgt_prv = prv_q[tgt];
    assign head    = head_q;
    assign tail    = tail_q;

    // Per-line link update decided by parallel index compares.
    for (genvar g = 0; g < LINES; g++) begin : g_link
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                nxt_q[g] <= IDX_W'((g + 1) % LINES);
                prv_q[g] <= IDX_W'((g + LINES - 1) % LINES);
            end else if (unlink_en) begin
                if (IDX_W'(g) == tgt_prv) nxt_q[g] <= tgt_nxt;
                if (IDX_W'(g) == tgt_nxt && tgt != tail_q) prv_q[g] <= tgt_prv;
            end else if (relink_en) begin
                if (IDX_W'(g) == tgt)    nxt_q[g] <= head_q;
                if (IDX_W'(g) == head_q) prv_q[g] <= tgt;
            end
        end
    end

    // Head and tail registers follow the splice.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q <= '0;
            tail_q <= IDX_W'(LINES - 1);
        end else if (unlink_en) begin
            if (tgt == tail_q) tail_q <= tgt_prv;
        end else if (relink_en) begin
            head_q <= tgt;
        end
    end

    AST_RELINK_CHAIN: assert property (@(posedge clk) disable iff (!rst_n)
        relink_en |=> (nxt_q[head_q] == $past(head_q)));  // R7
    AST_TAIL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(unlink_en || relink_en) |=> $stable(tail_q));  // R10

endmodule

// File: rtl/fa_tag_dir.sv
// Tag directory top: request capture, parallel match, flag update and
// three-step recency update. Assumes: synchronous active-low reset, one
// request in flight, LINES >= 2.
module fa_tag_dir #(
    parameter int ADDR_W = 32,
    parameter int OFFS_W = 6,
    parameter int LINES  = 1024,
    localparam int TAG_W = ADDR_W - OFFS_W,
    localparam int IDX_W = $clog2(LINES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    input  logic              req_fill,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [IDX_W-1:0]  rsp_idx,
    output logic [IDX_W-1:0]  rsp_victim_idx,
    output logic              rsp_victim_dirty
);
    import fa_pkg::*;

    fa_state_e                   state_q;
    logic [LINES-1:0][TAG_W-1:0] tag_q;
    logic [LINES-1:0]            valid_q;
    logic [LINES-1:0]            dirty_q;
    logic [TAG_W-1:0]            lk_tag;
    logic                        lk_wr;
    logic                        lk_fill;
    logic [IDX_W-1:0]            tgt_q;
    logic                        skip_q;
    logic [LINES-1:0]            match_vec;
    logic                        any_hit;
    logic [IDX_W-1:0]            hit_line;
    logic [IDX_W-1:0]            head;
    logic [IDX_W-1:0]            tail;
    logic [IDX_W-1:0]            tgt_c;
    logic                        accept;
    logic                        unused_offs;

    assign unused_offs = ^req_addr[OFFS_W-1:0];
    assign req_ready   = (state_q == ST_IDLE);
    assign accept      = req_valid && req_ready;
    assign tgt_c       = any_hit ? hit_line : tail;

    fa_tag_match #(.LINES(LINES), .TAG_W(TAG_W), .IDX_W(IDX_W)) u_match (
        .line_tag (tag_q),
        .line_vld (valid_q),
        .probe    (lk_tag),
        .match_vec(match_vec),
        .any_hit  (any_hit),
        .hit_line (hit_line)
    );

    fa_lru_chain #(.LINES(LINES), .IDX_W(IDX_W)) u_chain (
        .clk      (clk),
        .rst_n    (rst_n),
        .unlink_en(state_q == ST_UNLINK && !skip_q),
        .relink_en(state_q == ST_RELINK && !skip_q),
        .tgt      (tgt_q),
        .head     (head),
        .tail     (tail)
    );

    // Sequencer, line flags and response registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q          <= ST_IDLE;
            tag_q            <= '0;
            valid_q          <= '0;
            dirty_q          <= '0;
            lk_tag           <= '0;
            lk_wr            <= 1'b0;
            lk_fill          <= 1'b0;
            tgt_q            <= '0;
            skip_q           <= 1'b0;
            rsp_valid        <= 1'b0;
            rsp_hit          <= 1'b0;
            rsp_idx          <= '0;
            rsp_victim_idx   <= '0;
            rsp_victim_dirty <= 1'b0;
        end else begin
            rsp_valid <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        lk_tag  <= req_addr[ADDR_W-1:OFFS_W];
                        lk_wr   <= req_write;
                        lk_fill <= req_fill;
                        state_q <= ST_MATCH;
                    end
                end
                ST_MATCH: begin
                    rsp_valid        <= 1'b1;
                    rsp_hit          <= any_hit;
                    rsp_idx          <= tgt_c;
                    rsp_victim_idx   <= tail;
                    rsp_victim_dirty <= dirty_q[tail];
                    tgt_q            <= tgt_c;
                    skip_q           <= (tgt_c == head);
                    if (lk_fill) begin
                        tag_q[tgt_c]   <= lk_tag;
                        valid_q[tgt_c] <= 1'b1;
                        dirty_q[tgt_c] <= 1'b0;
                    end else if (any_hit && lk_wr) begin
                        dirty_q[hit_line] <= 1'b1;
                    end
                    state_q <= (any_hit || lk_fill) ? ST_UNLINK : ST_IDLE;
                end
                ST_UNLINK: state_q <= ST_RELINK;
                default:   state_q <= ST_IDLE;
            endcase
        end
    end

    AST_MATCH_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match_vec));  // R6
    AST_RSP_AFTER_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_MATCH) |=> rsp_valid);  // R3
    AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);  // R3
    AST_WRITE_DIRTY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_MATCH && any_hit && lk_wr && !lk_fill) |=> dirty_q[$past(hit_line)]);  // R5
    AST_FILL_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_MATCH && lk_fill) |=> (valid_q[$past(tgt_c)] && !dirty_q[$past(tgt_c)]));  // R6
    AST_BUSY_AFTER_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_MATCH && (any_hit || lk_fill)) |=> !req_ready);  // R8

endmodule

// File: tb/fa_tag_dir_bench.sv
`timescale 1ns/1ps
module fa_tag_dir_bench;
    localparam int LINES = 8;
    localparam int IDX_W = 3;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             req_valid = 1'b0;
    logic             req_ready;
    logic [31:0]      req_addr = '0;
    logic             req_write = 1'b0;
    logic             req_fill = 1'b0;
    logic             rsp_valid;
    logic             rsp_hit;
    logic [IDX_W-1:0] rsp_idx;
    logic [IDX_W-1:0] rsp_victim_idx;
    logic             rsp_victim_dirty;

    int n_chk  = 0;
    int n_fail = 0;

    // Bench model of the requirements
    logic [25:0] m_tag   [LINES];
    logic        m_val   [LINES];
    logic        m_dirty [LINES];
    int          m_ord   [LINES];   // m_ord[0] most recent

    always #2 clk = ~clk;

    fa_tag_dir #(.ADDR_W(32), .OFFS_W(6), .LINES(LINES)) u_fa_tag_dir (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_write(req_write), .req_fill(req_fill),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_idx(rsp_idx),
        .rsp_victim_idx(rsp_victim_idx), .rsp_victim_dirty(rsp_victim_dirty)
    );

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
        end
    endtask

    function automatic logic [31:0] tag_addr(input int t, input int offs);
        return {t[25:0], offs[5:0]};
    endfunction

    // One request with full checking; intrude drives a request while busy.
    task automatic op(input logic [31:0] addr, input logic wr, input logic fl,
                      input string lbl, input bit intrude);
        int  h;
        bit  ehit;
        int  evic;
        int  eidx;
        bit  evd;
        bit  upd;
        h = -1;
        for (int i = LINES - 1; i >= 0; i--)
            if (m_val[i] && m_tag[i] == addr[31:6]) h = i;
        ehit = (h >= 0);
        evic = m_ord[LINES-1];
        eidx = ehit ? h : evic;
        evd  = m_dirty[evic];
        upd  = ehit || fl;

        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_addr = addr; req_write = wr; req_fill = fl;
        @(negedge clk);
        req_valid = 1'b0;
        chk(req_ready == 1'b0, "R8 busy after accept", int'(req_ready), 0);
        if (intrude) begin
            req_valid = 1'b1; req_addr = 32'hFFFF_FFC0; req_fill = 1'b1; req_write = 1'b0;
        end
        @(negedge clk);
        chk(rsp_valid == 1'b1, "R3 response strobe", int'(rsp_valid), 1);
        chk(rsp_hit == ehit, {lbl, " R3 hit flag"}, int'(rsp_hit), int'(ehit));
        chk(int'(rsp_idx) == eidx, {lbl, " R3 line index"}, int'(rsp_idx), eidx);
        chk(int'(rsp_victim_idx) == evic, {lbl, " R4 victim index"}, int'(rsp_victim_idx), evic);
        chk(rsp_victim_dirty == evd, {lbl, " R4 victim dirty"}, int'(rsp_victim_dirty), int'(evd));
        chk(req_ready == !upd, "R8 ready after match", int'(req_ready), int'(!upd));
        if (upd) begin
            @(negedge clk);
            chk(rsp_valid == 1'b0, "R3 single pulse", int'(rsp_valid), 0);
            chk(req_ready == 1'b0, "R8 busy in relink", int'(req_ready), 0);
            if (intrude) req_valid = 1'b0;
            @(negedge clk);
            chk(req_ready == 1'b1, "R8 ready after update", int'(req_ready), 1);
            if (intrude) begin
                @(negedge clk);
                chk(rsp_valid == 1'b0, "R9 no response to busy request", int'(rsp_valid), 0);
                chk(req_ready == 1'b1, "R9 busy request not accepted", int'(req_ready), 1);
            end
        end
        // model update
        if (fl) begin
            m_tag[eidx] = addr[31:6]; m_val[eidx] = 1'b1; m_dirty[eidx] = 1'b0;
        end else if (ehit && wr) begin
            m_dirty[h] = 1'b1;
        end
        if (upd) begin
            int p;
            p = 0;
            for (int i = 0; i < LINES; i++) if (m_ord[i] == eidx) p = i;
            for (int i = p; i > 0; i--) m_ord[i] = m_ord[i-1];
            m_ord[0] = eidx;
        end
    endtask

    initial begin : watchdog
        #(4 * 200000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin : main
        int unsigned seed;
        for (int i = 0; i < LINES; i++) begin
            m_tag[i] = '0; m_val[i] = 1'b0; m_dirty[i] = 1'b0; m_ord[i] = i;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1, "R1 ready after reset", int'(req_ready), 1);
        chk(rsp_valid == 1'b0, "R1 no response after reset", int'(rsp_valid), 0);

        op(tag_addr(200, 0), 1'b0, 1'b0, "R1", 1'b0);
        for (int k = 0; k < LINES; k++) op(tag_addr(k + 1, 0), 1'b0, 1'b1, "R10", 1'b0);
        for (int k = 0; k < LINES; k++) op(tag_addr(((k * 3) % LINES) + 1, (k * 7 + 1) % 64), 1'b0, 1'b0, "R2", 1'b0);
        op(tag_addr(3, 12), 1'b1, 1'b0, "R5", 1'b0);
        op(tag_addr(6, 63), 1'b1, 1'b0, "R5", 1'b0);
        op(tag_addr(50, 0), 1'b1, 1'b0, "R5", 1'b0);
        op(tag_addr(60, 0), 1'b0, 1'b0, "R4", 1'b0);
        op(tag_addr(3, 0), 1'b1, 1'b1, "R6", 1'b0);
        op(tag_addr(3, 0), 1'b0, 1'b0, "R6", 1'b0);
        op(tag_addr(4, 0), 1'b0, 1'b0, "R9", 1'b1);
        op(32'hFFFF_FFC0, 1'b0, 1'b0, "R9", 1'b0);

        seed = 32'h1234_5678;
        for (int n = 0; n < 400; n++) begin
            int t;
            int o;
            bit w;
            bit f;
            seed = seed * 1103515245 + 12345; t = int'((seed >> 16) % 12) + 1;
            seed = seed * 1103515245 + 12345; o = int'((seed >> 16) % 64);
            seed = seed * 1103515245 + 12345; w = seed[20];
            seed = seed * 1103515245 + 12345; f = ((seed >> 16) % 3) == 0;
            op(tag_addr(t, o), w, f, "R7", 1'b0);
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule